// File: doc/BRIEF.md
# Burst SRAM Single-Read Sequencer

This block turns a level-sensitive enable into the active-low control sequence needed to fetch one word from a synchronous burst SRAM. While the enable is high it walks through three active states. The first state loads the address, using both address-load strobes and the advance strobe. The second state keeps only the controller-side load strobe low. The third state pulls advance and output enable low, and the memory returns data during that state.

The starting address is driven onto a tristated address bus only during the first active state, and the bus floats in every other state. The word on the memory's data bus is registered on the clock edge that leaves the read state, together with a one-cycle completion pulse. Dropping the enable early abandons the access. Holding the enable high repeats the access, with one idle cycle between reads.

Top module: `bsram_rd_ctrl`

## Requirements
- R1: During and after reset, with go_i low, the block is idle: cpu_ld_no, ctl_ld_no, adv_no, oe_no and ce_no are 1, ce_o is 0, addr_io is high-impedance and done_o is 0.
- R2: One clock edge after go_i is seen high in idle, the block is in the load state: cpu_ld_no=0, ctl_ld_no=0, adv_no=0, oe_no=1, and addr_io carries start_addr_i as sampled on that edge.
- R3: The state after load (go_i still high) is the hold state: cpu_ld_no=1, ctl_ld_no=0, adv_no=1, oe_no=1, addr_io high-impedance.
- R4: The state after hold (go_i still high) is the read state: cpu_ld_no=1, ctl_ld_no=1, adv_no=0, oe_no=0, addr_io high-impedance.
- R5: we_no is 1 in every cycle. The chip selects are asserted (ce_no=0, ce_o=1) in load, hold and read, and deasserted in idle.
- R6: If go_i is low at an edge in load or hold, the block returns to idle on that edge. No done_o pulse follows, and data_o keeps its previous value.
- R7: On the edge that leaves the read state, data_o takes the value of rd_data_i. done_o is 1 for exactly the following cycle and 0 otherwise.
- R8: The read state always moves to idle. If go_i stays high, a new load follows after exactly one idle cycle, so one access repeats every four cycles.
- R9: After the starting address has been sampled, changes on start_addr_i do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Access enable, level sensitive |
| start_addr_i | input | 16 | Starting address of the access |
| rd_data_i | input | 32 | Data bus from the memory |
| addr_io | inout | 16 | Memory address bus, driven only in the load state |
| cpu_ld_no | output | 1 | Processor-side address load strobe, active low |
| ctl_ld_no | output | 1 | Controller-side address load strobe, active low |
| adv_no | output | 1 | Address advance strobe, active low |
| oe_no | output | 1 | Output enable, active low |
| we_no | output | 1 | Write enable, active low (always inactive) |
| ce_no | output | 1 | Active-low chip select |
| ce_o | output | 1 | Active-high chip select |
| data_o | output | 32 | Captured read word |
| done_o | output | 1 | One-cycle pulse marking a new captured word |

## Verification
Two events can fall in the same cycle. One is the completion pulse and capture from the previous access. The other is the idle cycle that precedes the next load while go_i stays high. The back-to-back scenario keeps go_i high across two accesses and changes rd_data_i between them. In the idle cycle between the two accesses it checks that done_o is high, that data_o holds the first word, and that the strobes show idle. The next cycle must then be a load carrying the newly sampled address, and the second capture must hold the second word.

// File: rtl/bsram_rd_pkg.sv
package bsram_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_HOLD = 2'd2,
    ST_READ = 2'd3
  } rd_state_e;

  typedef struct packed {
    logic cpu_ld_n;
    logic ctl_ld_n;
    logic adv_n;
    logic oe_n;
    logic drive;
    logic active;
  } strobe_t;
endpackage

// File: rtl/bsram_rd_seq.sv
module bsram_rd_seq
  import bsram_rd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] start_addr_i,
  output rd_state_e     state_o,
  output logic [AW-1:0] addr_o
);
  rd_state_e state_q, state_d;
  logic [AW-1:0] addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_i) state_d = ST_LOAD;
      ST_LOAD: state_d = go_i ? ST_HOLD : ST_IDLE;
      ST_HOLD: state_d = go_i ? ST_READ : ST_IDLE;
      ST_READ: state_d = ST_IDLE; // always rest one cycle
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go_i) addr_q <= start_addr_i;
    end
  end

  // R8
  read_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_READ |=> state_q == ST_IDLE);

  assign state_o = state_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/bsram_rd_decode.sv
module bsram_rd_decode
  import bsram_rd_pkg::*;
(
  input  rd_state_e state_i,
  output strobe_t   strobe_o
);
  always_comb begin
    unique case (state_i)
      ST_LOAD: strobe_o = '{cpu_ld_n: 1'b0, ctl_ld_n: 1'b0, adv_n: 1'b0, oe_n: 1'b1, drive: 1'b1, active: 1'b1};
      ST_HOLD: strobe_o = '{cpu_ld_n: 1'b1, ctl_ld_n: 1'b0, adv_n: 1'b1, oe_n: 1'b1, drive: 1'b0, active: 1'b1};
      ST_READ: strobe_o = '{cpu_ld_n: 1'b1, ctl_ld_n: 1'b1, adv_n: 1'b0, oe_n: 1'b0, drive: 1'b0, active: 1'b1};
      default: strobe_o = '{cpu_ld_n: 1'b1, ctl_ld_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1, drive: 1'b0, active: 1'b0};
    endcase
  end
endmodule

// File: rtl/bsram_rd_capture.sv
module bsram_rd_capture
  import bsram_rd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rd_state_e     state_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  logic [DW-1:0] data_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (state_i == ST_READ);
      if (state_i == ST_READ) data_q <= rd_data_i;
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assign data_o = data_q;
  assign done_o = done_q;
endmodule

// File: rtl/bsram_rd_ctrl.sv
module bsram_rd_ctrl
  import bsram_rd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] rd_data_i,
  inout  wire  [AW-1:0] addr_io,
  output logic          cpu_ld_no,
  output logic          ctl_ld_no,
  output logic          adv_no,
  output logic          oe_no,
  output logic          we_no,
  output logic          ce_no,
  output logic          ce_o,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  rd_state_e     state;
  logic [AW-1:0] addr;
  strobe_t       strobe;

  bsram_rd_seq #(.AW(AW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go_i),
    .start_addr_i (start_addr_i),
    .state_o      (state),
    .addr_o       (addr)
  );

  bsram_rd_decode u_dec (
    .state_i  (state),
    .strobe_o (strobe)
  );

  bsram_rd_capture #(.DW(DW)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .rd_data_i (rd_data_i),
    .data_o    (data_o),
    .done_o    (done_o)
  );

  assign addr_io   = strobe.drive ? addr : {AW{1'bz}};
  assign cpu_ld_no = strobe.cpu_ld_n;
  assign ctl_ld_no = strobe.ctl_ld_n;
  assign adv_no    = strobe.adv_n;
  assign oe_no     = strobe.oe_n;
  assign we_no     = 1'b1;
  assign ce_no     = ~strobe.active;
  assign ce_o      = strobe.active;

  // R2
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_ld_no |-> addr_io === $past(start_addr_i));

  // R4
  read_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> $past(!ctl_ld_no && cpu_ld_no));

  // R6
  go_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!go_i && oe_no) |=> ce_no);

  // R7
  done_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!oe_no));
endmodule

// File: tb/bsram_rd_ctrl_test.sv
module bsram_rd_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        go_i = 1'b0;
  logic [15:0] start_addr_i = '0;
  logic [31:0] rd_data_i = '0;
  wire  [15:0] addr_io;
  logic cpu_ld_no, ctl_ld_no, adv_no, oe_no, we_no, ce_no, ce_o, done_o;
  logic [31:0] data_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  bsram_rd_ctrl uut (
    .clk_i, .rst_ni, .go_i, .start_addr_i, .rd_data_i, .addr_io,
    .cpu_ld_no, .ctl_ld_no, .adv_no, .oe_no, .we_no, .ce_no, .ce_o,
    .data_o, .done_o
  );

  localparam logic [6:0] P_IDLE = 7'b1111_110; // cpu,ctl,adv,oe,we,ce_n,ce
  localparam logic [6:0] P_LOAD = 7'b0001_101;
  localparam logic [6:0] P_HOLD = 7'b1011_101;
  localparam logic [6:0] P_READ = 7'b1100_101;

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk_pins(string req, logic [6:0] exp_p, logic [15:0] exp_a);
    logic [6:0] act = {cpu_ld_no, ctl_ld_no, adv_no, oe_no, we_no, ce_no, ce_o};
    n_run++;
    if (act !== exp_p || addr_io !== exp_a) begin
      n_fail++;
      $display("FAIL %s pins act=%b addr=%h exp=%b addr=%h", req, act, addr_io, exp_p, exp_a);
    end
  endtask

  task automatic chk_out(string req, logic exp_done, logic [31:0] exp_d);
    n_run++;
    if (done_o !== exp_done || data_o !== exp_d) begin
      n_fail++;
      $display("FAIL %s done=%b data=%h exp done=%b data=%h", req, done_o, data_o, exp_done, exp_d);
    end
  endtask

  task automatic t_reset();
    #1;
    chk_pins("R1 in reset", P_IDLE, 16'hzzzz);
    chk_out("R1 in reset", 1'b0, 32'h0);
    step(); step();
    rst_ni = 1'b1;
    step();
    chk_pins("R1 after reset", P_IDLE, 16'hzzzz);
    chk_out("R1 after reset", 1'b0, 32'h0);
  endtask

  task automatic t_single();
    start_addr_i = 16'h1234;
    go_i = 1'b1;
    step();
    chk_pins("R2 R5 load", P_LOAD, 16'h1234);
    start_addr_i = 16'hBEEF; // R9
    rd_data_i = 32'hCAFE_F00D;
    step();
    chk_pins("R3 R9 hold", P_HOLD, 16'hzzzz);
    step();
    chk_pins("R4 read", P_READ, 16'hzzzz);
    chk_out("R7 no done in read", 1'b0, 32'h0);
    go_i = 1'b0;
    rd_data_i = 32'h1357_9BDF;
    step();
    chk_pins("R8 idle after read", P_IDLE, 16'hzzzz);
    chk_out("R7 capture", 1'b1, 32'h1357_9BDF);
    rd_data_i = 32'h0;
    step();
    chk_out("R7 single pulse", 1'b0, 32'h1357_9BDF);
  endtask

  task automatic t_abort();
    start_addr_i = 16'h00A5;
    rd_data_i = 32'hDEAD_BEEF;
    go_i = 1'b1;
    step();
    chk_pins("R2 load abort A", P_LOAD, 16'h00A5);
    go_i = 1'b0;
    step();
    chk_pins("R6 abort from load", P_IDLE, 16'hzzzz);
    step();
    chk_out("R6 no done after load abort", 1'b0, 32'h1357_9BDF);
    go_i = 1'b1;
    step();
    step();
    chk_pins("R3 hold abort B", P_HOLD, 16'hzzzz);
    go_i = 1'b0;
    step();
    chk_pins("R6 abort from hold", P_IDLE, 16'hzzzz);
    step();
    chk_out("R6 no done after hold abort", 1'b0, 32'h1357_9BDF);
  endtask

  task automatic t_back2back();
    start_addr_i = 16'h4000;
    rd_data_i = 32'hAAAA_0001;
    go_i = 1'b1;
    step();
    chk_pins("R8 first load", P_LOAD, 16'h4000);
    start_addr_i = 16'h4100;
    step(); step();
    chk_pins("R8 first read", P_READ, 16'hzzzz);
    step();
    chk_pins("R8 idle gap", P_IDLE, 16'hzzzz);
    chk_out("R7 R8 first capture", 1'b1, 32'hAAAA_0001);
    rd_data_i = 32'hBBBB_0002;
    step();
    chk_pins("R8 R9 second load", P_LOAD, 16'h4100);
    chk_out("R7 done cleared", 1'b0, 32'hAAAA_0001);
    step();
    chk_pins("R3 second hold", P_HOLD, 16'hzzzz);
    step();
    chk_pins("R4 second read", P_READ, 16'hzzzz);
    go_i = 1'b0;
    step();
    chk_out("R7 second capture", 1'b1, 32'hBBBB_0002);
    chk_pins("R5 idle deselect", P_IDLE, 16'hzzzz);
  endtask

  initial begin
    t_reset();
    t_single();
    t_abort();
    t_back2back();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule